// File: doc/BRIEF.md
# Frame Buffer Burst Address Sequencer

This block walks a display controller through the memory bursts of one video field. Software-visible settings arrive as plain inputs: two buffer base addresses, the number of lines in a field, the number of bursts in each line, a line-to-line gap measured in whole bursts, and a flag that restricts fetching to buffer A. A one-cycle start pulse opens a field. The block then presents one burst address per handshake on a ready/valid output, together with flags that mark the final burst of a line and the final burst of the field.

Addresses are kept internally as burst indices and are scaled to bytes by a power-of-two burst size parameter. After the final burst of each line the index skips the programmed gap. A gap of zero gives progressive scan. A gap equal to the burst count reads every other stored line, which gives interlace. A nonzero gap combined with an offset base gives a panned window into a wider buffer. In dual-buffer operation successive fields alternate between buffers A and B. A start with a zero line or burst count is refused and flagged.

Top module: `fb_burst_seq`

## Requirements
- R1: After synchronous reset, out_valid, cfg_err and out_buf_b are all 0 and the block is idle.
- R2: A start accepted while idle raises out_valid in the next cycle with out_addr = base × BURST_BYTES of the chosen buffer. All settings are captured at that start, and later changes to them have no effect on the running field.
- R3: Within a line, each handshake (out_valid and out_ready both 1) advances out_addr by exactly BURST_BYTES.
- R4: out_last_line is 1 on the final burst of every line. After that handshake the next address is the previous one plus (1 + gap) × BURST_BYTES.
- R5: A field delivers lines × bursts handshakes. out_last_field is 1 only on the last of them, together with out_last_line. After it, out_valid is 0 in the next cycle.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_addr stays unchanged.
- R7: A start while idle with lines = 0 or bursts = 0 sets cfg_err to 1 and produces no output. An accepted start clears cfg_err.
- R8: With single_buf = 1, the field uses buffer A (out_buf_b = 0). With single_buf = 0, the field uses the buffer other than the one used by the previous accepted field. Buffer A is used first after reset. out_buf_b shows the buffer of the current field (0 = A, 1 = B).
- R9: A start pulse while a field is streaming is ignored. This includes the cycle of the field's final handshake. The field continues unchanged, and the buffer choice is not advanced.
- R10: With gap equal to bursts, consecutive lines of a field begin 2 × bursts × BURST_BYTES apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Field start pulse |
| base_a | input | ADDR_W | Buffer A start, in bursts |
| base_b | input | ADDR_W | Buffer B start, in bursts |
| lines | input | LINE_W | Lines per field |
| bursts | input | BPL_W | Bursts per line |
| gap | input | GAP_W | Bursts skipped after each line |
| single_buf | input | 1 | 1 = fetch only from buffer A |
| out_ready | input | 1 | Consumer accepts the current burst |
| out_valid | output | 1 | Burst address is presented |
| out_addr | output | ADDR_W+log2(BURST_BYTES) | Byte address of the burst |
| out_last_line | output | 1 | Final burst of a line |
| out_last_field | output | 1 | Final burst of the field |
| out_buf_b | output | 1 | Buffer of the current or most recent field |
| cfg_err | output | 1 | Last idle start was refused |

## Verification
Two pairs of events can coincide. A start pulse can arrive in the same cycle as a burst handshake, and the end of a line can coincide with the end of the field. The bench pulses start in mid-field and again in exactly the cycle of the final handshake. It then checks that the address stream stays intact, that out_valid drops afterwards, and that the next field still gets the buffer predicted from accepted starts alone. Single-burst lines and a one-line field make line-end and field-end fall together, and every flag is compared on every handshake, including under a back-pressure pattern.

// File: rtl/fb_seq_pkg.sv
package fb_seq_pkg;

   typedef enum logic {BUF_A = 1'b0, BUF_B = 1'b1} buf_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/fb_seq_cnt.sv
// Position counter: clears, steps, and flags when it sits at the captured final value.
module fb_seq_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         inc,
   input  logic [W-1:0] last_val,
   output logic         at_last
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || clr) cnt <= '0;
      else if (inc)   cnt <= cnt + 1'b1;
   end

   assign at_last = (cnt == last_val);
endmodule

// File: rtl/fb_seq_cfg.sv
// Start qualification, settings capture and buffer alternation.
module fb_seq_cfg #(
   parameter int ADDR_W = 20,
   parameter int LINE_W = 11,
   parameter int BPL_W  = 8,
   parameter int GAP_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              idle,
   input  logic [ADDR_W-1:0] base_a,
   input  logic [ADDR_W-1:0] base_b,
   input  logic [LINE_W-1:0] lines,
   input  logic [BPL_W-1:0]  bursts,
   input  logic [GAP_W-1:0]  gap,
   input  logic              single_buf,
   output logic              accept,
   output logic              cfg_err,
   output logic [ADDR_W-1:0] start_base,
   output logic [LINE_W-1:0] lines_m1,
   output logic [BPL_W-1:0]  bursts_m1,
   output logic [GAP_W-1:0]  gap_q,
   output logic              buf_b
);
   import fb_seq_pkg::*;

   logic bad_cfg;
   buf_e nxt_buf, cur_buf;

   assign bad_cfg    = (lines == '0) || (bursts == '0);
   assign accept     = start && idle && !bad_cfg;
   assign cur_buf    = single_buf ? BUF_A : nxt_buf;
   assign start_base = (cur_buf == BUF_B) ? base_b : base_a;

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_err   <= 1'b0;
         nxt_buf   <= BUF_A;
         buf_b     <= 1'b0;
         lines_m1  <= '0;
         bursts_m1 <= '0;
         gap_q     <= '0;
      end else if (accept) begin
         cfg_err   <= 1'b0;
         nxt_buf   <= (cur_buf == BUF_A) ? BUF_B : BUF_A;
         buf_b     <= (cur_buf == BUF_B);
         lines_m1  <= lines - 1'b1;
         bursts_m1 <= bursts - 1'b1;
         gap_q     <= gap;
      end else if (start && idle) begin
         cfg_err   <= 1'b1;
      end
   end
endmodule

// File: rtl/fb_seq_addr.sv
// Burst index accumulator: +1 inside a line, +1+gap at a line end.
module fb_seq_addr #(
   parameter int ADDR_W = 20,
   parameter int GAP_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   input  logic              at_eol,
   input  logic [GAP_W-1:0]  gap,
   output logic [ADDR_W-1:0] idx
);
   logic [ADDR_W-1:0] stride;

   assign stride = at_eol ? (ADDR_W'(gap) + ADDR_W'(1)) : ADDR_W'(1);

   always_ff @(posedge clk) begin
      if (rst)       idx <= '0;
      else if (load) idx <= load_val;
      else if (step) idx <= idx + stride;
   end
endmodule

// File: rtl/fb_burst_seq.sv
module fb_burst_seq #(
   parameter int ADDR_W      = 20,
   parameter int LINE_W      = 11,
   parameter int BPL_W       = 8,
   parameter int GAP_W       = 8,
   parameter int BURST_BYTES = 16,
   localparam int BYTE_SH    = $clog2(BURST_BYTES),
   localparam int BYTE_W     = ADDR_W + BYTE_SH
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_a,
   input  logic [ADDR_W-1:0] base_b,
   input  logic [LINE_W-1:0] lines,
   input  logic [BPL_W-1:0]  bursts,
   input  logic [GAP_W-1:0]  gap,
   input  logic              single_buf,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_addr,
   output logic              out_last_line,
   output logic              out_last_field,
   output logic              out_buf_b,
   output logic              cfg_err
);
   generate
      if (!fb_seq_pkg::is_pow2(BURST_BYTES)) begin : g_bad_burst
         $error("BURST_BYTES must be a power of two");
      end
      if (GAP_W > ADDR_W) begin : g_bad_gap
         $error("GAP_W must not exceed ADDR_W");
      end
      if (LINE_W < 1 || BPL_W < 1) begin : g_bad_cnt
         $error("counter widths must be positive");
      end
   endgenerate

   logic              running, fire, accept;
   logic              col_last, line_last;
   logic [ADDR_W-1:0] start_base, idx;
   logic [LINE_W-1:0] lines_m1;
   logic [BPL_W-1:0]  bursts_m1;
   logic [GAP_W-1:0]  gap_q;

   fb_seq_cfg #(
      .ADDR_W(ADDR_W), .LINE_W(LINE_W), .BPL_W(BPL_W), .GAP_W(GAP_W)
   ) u_cfg (
      .clk(clk), .rst(rst), .start(start), .idle(!running),
      .base_a(base_a), .base_b(base_b), .lines(lines), .bursts(bursts),
      .gap(gap), .single_buf(single_buf),
      .accept(accept), .cfg_err(cfg_err), .start_base(start_base),
      .lines_m1(lines_m1), .bursts_m1(bursts_m1), .gap_q(gap_q),
      .buf_b(out_buf_b)
   );

   assign fire = running && out_ready;

   fb_seq_cnt #(.W(BPL_W)) u_col (
      .clk(clk), .rst(rst), .clr(accept || (fire && col_last)),
      .inc(fire), .last_val(bursts_m1), .at_last(col_last)
   );

   fb_seq_cnt #(.W(LINE_W)) u_line (
      .clk(clk), .rst(rst), .clr(accept),
      .inc(fire && col_last), .last_val(lines_m1), .at_last(line_last)
   );

   fb_seq_addr #(.ADDR_W(ADDR_W), .GAP_W(GAP_W)) u_addr (
      .clk(clk), .rst(rst), .load(accept), .load_val(start_base),
      .step(fire), .at_eol(col_last), .gap(gap_q), .idx(idx)
   );

   always_ff @(posedge clk) begin
      if (rst)                                running <= 1'b0;
      else if (accept)                        running <= 1'b1;
      else if (fire && col_last && line_last) running <= 1'b0;
   end

   assign out_valid      = running;
   assign out_last_line  = running && col_last;
   assign out_last_field = running && col_last && line_last;

   generate
      if (BYTE_SH == 0) begin : g_unit_burst
         assign out_addr = idx;
      end else begin : g_scaled_burst
         assign out_addr = {idx, {BYTE_SH{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/fb_seq_chk.sv
module fb_seq_chk #(
   parameter int BYTE_W      = 24,
   parameter int BURST_BYTES = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              start,
   input logic              out_ready,
   input logic              out_valid,
   input logic [BYTE_W-1:0] out_addr,
   input logic              out_last_line,
   input logic              out_last_field,
   input logic              cfg_err
);
   // R3
   p_step_in_line_r3: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_ready && !out_last_line |=>
         out_valid && (out_addr == BYTE_W'($past(out_addr) + BURST_BYTES)));

   // R5
   p_field_end_flags_r5: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_last_field |-> out_last_line);

   // R5
   p_drop_only_at_end_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(out_valid) |-> $past(out_ready && out_last_field));

   // R6
   p_hold_on_stall_r6: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_addr));

   // R7
   p_err_source_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(cfg_err) |-> $past(start) && !$past(out_valid) && !out_valid);

   // R1
   p_idle_flags_r1: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> !out_last_line && !out_last_field);
endmodule

bind fb_burst_seq fb_seq_chk #(
   .BYTE_W(BYTE_W), .BURST_BYTES(BURST_BYTES)
) u_chk (
   .clk(clk), .rst(rst), .start(start), .out_ready(out_ready),
   .out_valid(out_valid), .out_addr(out_addr),
   .out_last_line(out_last_line), .out_last_field(out_last_field),
   .cfg_err(cfg_err)
);

// File: tb/fb_burst_seq_tb.sv
module fb_burst_seq_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [19:0] base_a = '0, base_b = '0;
   logic [10:0] lines = '0;
   logic [7:0]  bursts = '0, gap = '0;
   logic        single_buf = 1'b0, out_ready = 1'b0;
   logic        out_valid, out_last_line, out_last_field, out_buf_b, cfg_err;
   logic [23:0] out_addr;

   int total = 0, bad = 0, phase = 0;

   always #4 clk = ~clk;

   fb_burst_seq u_dut (
      .clk(clk), .rst(rst), .start(start), .base_a(base_a), .base_b(base_b),
      .lines(lines), .bursts(bursts), .gap(gap), .single_buf(single_buf),
      .out_ready(out_ready), .out_valid(out_valid), .out_addr(out_addr),
      .out_last_line(out_last_line), .out_last_field(out_last_field),
      .out_buf_b(out_buf_b), .cfg_err(cfg_err)
   );

   task automatic check(input bit ok, input string rq, input string what,
                        input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
      end
   endtask

   // Pulse start with the given settings, then scramble them (R2 capture).
   task automatic kick(input logic [19:0] ba, bb, input int ln, bp, gp, input bit sb);
      @(negedge clk);
      base_a = ba; base_b = bb; lines = 11'(ln); bursts = 8'(bp);
      gap = 8'(gp); single_buf = sb; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      base_a = ~ba; base_b = ~bb; lines = 11'd1; bursts = 8'd1; gap = 8'd5;
      single_buf = ~sb;
   endtask

   // Consume one field and compare every handshake against the model.
   task automatic run_field(input logic [19:0] base, input int ln, bp, gp,
                            input bit stall, input int poke, input string rq);
      int n = 0;
      for (int l = 0; l < ln; l++) begin
         for (int c = 0; c < bp; c++) begin
            logic [19:0] bi = base + 20'(l * (bp + gp) + c);
            logic [23:0] ea = {bi, 4'h0};
            bit el = (c == bp - 1);
            bit ef = el && (l == ln - 1);
            forever begin
               out_ready = stall ? ((phase % 3) != 2) : 1'b1;
               phase++;
               start = (n == poke);
               #1;
               if (!out_valid) begin
                  check(1'b0, rq, "valid missing", 0, 1);
                  start = 1'b0; out_ready = 1'b0;
                  return;
               end
               if (out_ready) begin
                  check(out_addr == ea && out_last_line == el && out_last_field == ef,
                        rq, "burst addr/last_line/last_field",
                        {out_addr, out_last_line, out_last_field}, {ea, el, ef});
                  n++;
                  @(negedge clk);
                  break;
               end
               @(negedge clk);
               check(out_valid && out_addr == ea, "R6", "held during stall",
                     out_addr, ea);
            end
         end
      end
      start = 1'b0; out_ready = 1'b0;
      #1;
      check(!out_valid, "R5", "idle after field", out_valid, 0);
      check(n == ln * bp, "R5", "handshake count", n, ln * bp);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check(!out_valid && !cfg_err && !out_buf_b, "R1", "reset state",
            {out_valid, cfg_err, out_buf_b}, 0);
   endtask

   task automatic t_progressive();
      kick(20'h00100, 20'h40000, 3, 4, 0, 1'b0);
      check(out_valid && out_buf_b == 1'b0, "R2", "first field on A",
            {out_valid, out_buf_b}, 2'b10);
      run_field(20'h00100, 3, 4, 0, 1'b0, -1, "R3 R4 R5");
   endtask

   task automatic t_interlace_stall();
      kick(20'h00100, 20'h40000, 2, 3, 3, 1'b0);
      check(out_buf_b == 1'b1, "R8", "second dual field on B", out_buf_b, 1);
      run_field(20'h40000, 2, 3, 3, 1'b1, -1, "R10 R4 R6");
   endtask

   task automatic t_start_while_busy();
      kick(20'h00200, 20'h40000, 2, 2, 1, 1'b0);
      check(out_buf_b == 1'b0, "R8", "third dual field on A", out_buf_b, 0);
      run_field(20'h00200, 2, 2, 1, 1'b0, 1, "R9");
      kick(20'h00300, 20'h50000, 1, 1, 0, 1'b0);
      check(out_buf_b == 1'b1, "R9", "ignored start did not toggle", out_buf_b, 1);
      run_field(20'h50000, 1, 1, 0, 1'b0, 0, "R9 R5");
   endtask

   task automatic t_bad_config();
      kick(20'h00400, 20'h60000, 0, 4, 0, 1'b0);
      check(cfg_err && !out_valid, "R7", "zero lines refused",
            {cfg_err, out_valid}, 2'b10);
      repeat (3) @(negedge clk);
      check(!out_valid, "R7", "no output after refusal", out_valid, 0);
      kick(20'h00400, 20'h60000, 4, 0, 0, 1'b0);
      check(cfg_err && !out_valid, "R7", "zero bursts refused",
            {cfg_err, out_valid}, 2'b10);
      kick(20'h00400, 20'h60000, 3, 1, 2, 1'b0);
      check(!cfg_err && out_buf_b == 1'b0, "R7", "accepted start clears err, A next",
            {cfg_err, out_buf_b}, 0);
      run_field(20'h00400, 3, 1, 2, 1'b1, -1, "R4 R5");
   endtask

   task automatic t_single_buffer();
      kick(20'h00500, 20'h70000, 1, 3, 0, 1'b1);
      check(out_buf_b == 1'b0, "R8", "single mode on A", out_buf_b, 0);
      run_field(20'h00500, 1, 3, 0, 1'b0, -1, "R8");
      kick(20'h00510, 20'h70000, 2, 2, 0, 1'b1);
      check(out_buf_b == 1'b0, "R8", "single mode stays A", out_buf_b, 0);
      run_field(20'h00510, 2, 2, 0, 1'b0, -1, "R8");
      kick(20'h00520, 20'h70000, 1, 2, 0, 1'b0);
      check(out_buf_b == 1'b1, "R8", "dual after single goes to B", out_buf_b, 1);
      run_field(20'h70000, 1, 2, 0, 1'b0, -1, "R8 R2");
   endtask

   task automatic t_last_field_cycle_start();
      kick(20'h00600, 20'h70000, 2, 2, 0, 1'b0);
      run_field(20'h00600, 2, 2, 0, 1'b0, 3, "R9");
      repeat (2) @(negedge clk);
      check(!out_valid, "R9", "start on final handshake ignored", out_valid, 0);
   endtask

   initial begin
      #(8 * 200000);
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_progressive();
      t_interlace_stall();
      t_start_while_busy();
      t_bad_config();
      t_single_buffer();
      t_last_field_cycle_start();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule